// File: doc/BRIEF.md
# Priority Interrupt Level Encoder

This block gathers eight level-sensitive interrupt request lines from peripherals and turns them into the priority level and autovector number that a 68k-style processor expects. Each clock the request lines are copied into a pending register. A line's pending bit therefore stays set only while the line is held high. The highest-numbered pending line selects the outputs.

The winning line index i drives level i+1 and vector number i+25. The level field is three bits wide, so line 7 saturates at level 7, while its vector number still reads 32. When no line is pending, both outputs are zero. The level and vector are registered and change on the same clock edge as the pending register. They therefore reflect the request lines one clock after the edge that sampled them. A read-only copy of the pending register is brought out for observation.

Reset is asynchronous and active-low. Its release is synchronised inside the block through two flops, so the first request sample is taken on the third rising edge after reset is released.

Top module: `irq_level_encoder`

## Requirements
- R1: On each active rising edge, the pending view takes the value of the eight request lines present at that edge. Bit i of the pending view holds line i.
- R2: A request line that goes low clears its pending bit on the next active edge. No request is remembered after its line drops.
- R3: When several lines are pending, only the highest-numbered one determines the level and vector. Lower-numbered pending lines have no effect on either output.
- R4: When line i (0 to 6) is the highest pending line, the level output is i+1 and the vector output is i+25.
- R5: When no line is pending, both the level and the vector outputs are zero.
- R6: Asserting rst_n low clears the pending view, level and vector at once. After rst_n rises, the first two rising edges leave them at zero, and the third rising edge samples the requests.
- R7: When line 7 is pending, the level output saturates at 7 and the vector output is 32.
- R8: The level and vector outputs change on the same edge as the pending view. This is one clock after the request lines are sampled, with no further delay.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, release synchronised internally |
| irq_req | input | 8 | Level-sensitive request lines, bit i is line i |
| cpu_level | output | 3 | Registered interrupt priority level, 0 when idle |
| cpu_vector | output | 8 | Registered autovector number, 25..32 or 0 when idle |
| pend_view | output | 8 | Read-only copy of the pending register |

## Verification
The assertions assume that the request lines are stable around each rising clock edge, because they compare the pending register with the request value from the previous sampled cycle. They also assume that rst_n is held low for at least one edge at start-up.

The stimulus changes irq_req and rst_n only at falling edges, so each rising edge sees settled values. Each pattern is held for one or more cycles. This exercises both transitions and steady states, including a reset asserted in the middle of the run while requests are active.

// File: rtl/irqenc_pkg.sv
package irqenc_pkg;

  // Saturating level for a winning index: index + 1, clipped to the field maximum.
  function automatic int unsigned sat_level(input int unsigned idx, input int unsigned lvl_max);
    int unsigned raw;
    raw = idx + 1;
    return (raw > lvl_max) ? lvl_max : raw;
  endfunction

  // Autovector number for a winning index.
  function automatic int unsigned vec_number(input int unsigned idx, input int unsigned base);
    return idx + base;
  endfunction

endpackage

// File: rtl/irqenc_rst_sync.sv
module irqenc_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_int_n
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign rst_int_n = sync_q[STAGES-1];

endmodule

// File: rtl/irqenc_pend_reg.sv
module irqenc_pend_reg #(
  parameter int NUM_LINES = 8
) (
  input  logic                 clk,
  input  logic                 rst_int_n,
  input  logic [NUM_LINES-1:0] req,
  output logic [NUM_LINES-1:0] pend_q
);

  logic [NUM_LINES-1:0] pend_d;
  logic                 pend_en;

  always_comb begin
    pend_d  = req;
    pend_en = (pend_d != pend_q);
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n)   pend_q <= '0;
    else if (pend_en) pend_q <= pend_d;
  end

  logic was_active_q;
  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) was_active_q <= 1'b0;
    else            was_active_q <= 1'b1;
  end

  // R1 R2
  pend_follow_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    was_active_q |-> pend_q == $past(req));

  // R6
  pend_reset_chk: assert property (@(posedge clk)
    !rst_int_n |-> pend_q == '0);

endmodule

// File: rtl/irqenc_prio_find.sv
module irqenc_prio_find #(
  parameter int NUM_LINES = 8,
  localparam int IDX_W = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1
) (
  input  logic [NUM_LINES-1:0] req,
  output logic                 any,
  output logic [IDX_W-1:0]     idx
);

  // One-hot winner: a line wins when it is set and nothing above it is set.
  logic [NUM_LINES-1:0] above;
  logic [NUM_LINES-1:0] win;

  assign above[NUM_LINES-1] = 1'b0;
  genvar g;
  generate
    for (g = NUM_LINES - 2; g >= 0; g--) begin : g_above
      assign above[g] = above[g+1] | req[g+1];
    end
    for (g = 0; g < NUM_LINES; g++) begin : g_win
      assign win[g] = req[g] & ~above[g];
    end
  endgenerate

  always_comb begin
    idx = '0;
    for (int i = 0; i < NUM_LINES; i++) begin
      if (win[i]) idx = IDX_W'(i);
    end
    any = |req;
  end

endmodule

// File: rtl/irqenc_out_map.sv
module irqenc_out_map
  import irqenc_pkg::*;
#(
  parameter int NUM_LINES = 8,
  parameter int LVL_W     = 3,
  parameter int VEC_W     = 8,
  parameter int VEC_BASE  = 25,
  localparam int IDX_W    = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1,
  localparam int LVL_MAX  = (1 << LVL_W) - 1
) (
  input  logic             clk,
  input  logic             rst_int_n,
  input  logic             any,
  input  logic [IDX_W-1:0] idx,
  output logic [LVL_W-1:0] level_q,
  output logic [VEC_W-1:0] vector_q
);

  logic [LVL_W-1:0] level_d;
  logic [VEC_W-1:0] vector_d;
  logic             out_en;

  always_comb begin
    if (any) begin
      level_d  = LVL_W'(sat_level(int'(idx), LVL_MAX));
      vector_d = VEC_W'(vec_number(int'(idx), VEC_BASE));
    end else begin
      level_d  = '0;
      vector_d = '0;
    end
    out_en = (level_d != level_q) || (vector_d != vector_q);
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      level_q  <= '0;
      vector_q <= '0;
    end else if (out_en) begin
      level_q  <= level_d;
      vector_q <= vector_d;
    end
  end

  // R4
  vec_range_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    level_q != '0 |-> (vector_q >= VEC_W'(VEC_BASE)) &&
                      (vector_q <= VEC_W'(VEC_BASE + NUM_LINES - 1)));

  // R7
  level_sat_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    vector_q == VEC_W'(VEC_BASE + NUM_LINES - 1) |-> level_q == LVL_W'(LVL_MAX));

endmodule

// File: rtl/irq_level_encoder.sv
module irq_level_encoder #(
  parameter int NUM_LINES = 8,
  parameter int LVL_W     = 3,
  parameter int VEC_W     = 8,
  parameter int VEC_BASE  = 25
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_LINES-1:0] irq_req,
  output logic [LVL_W-1:0]     cpu_level,
  output logic [VEC_W-1:0]     cpu_vector,
  output logic [NUM_LINES-1:0] pend_view
);

  localparam int IDX_W = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1;

  logic             rst_int_n;
  logic             win_any;
  logic [IDX_W-1:0] win_idx;

  irqenc_rst_sync #(.STAGES(2)) u_rst (
    .clk       (clk),
    .rst_n     (rst_n),
    .rst_int_n (rst_int_n)
  );

  irqenc_pend_reg #(.NUM_LINES(NUM_LINES)) u_pend (
    .clk       (clk),
    .rst_int_n (rst_int_n),
    .req       (irq_req),
    .pend_q    (pend_view)
  );

  // The winner is taken from the value being loaded, so outputs move with the pending register.
  irqenc_prio_find #(.NUM_LINES(NUM_LINES)) u_find (
    .req (irq_req),
    .any (win_any),
    .idx (win_idx)
  );

  irqenc_out_map #(
    .NUM_LINES (NUM_LINES),
    .LVL_W     (LVL_W),
    .VEC_W     (VEC_W),
    .VEC_BASE  (VEC_BASE)
  ) u_map (
    .clk       (clk),
    .rst_int_n (rst_int_n),
    .any       (win_any),
    .idx       (win_idx),
    .level_q   (cpu_level),
    .vector_q  (cpu_vector)
  );

  logic [IDX_W-1:0] out_idx;
  assign out_idx = IDX_W'(cpu_vector - VEC_W'(VEC_BASE));

  // R5
  idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    pend_view == '0 |-> (cpu_level == '0) && (cpu_vector == '0));

  // R3
  top_wins_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    cpu_vector != '0 |-> pend_view[out_idx] && ((pend_view >> out_idx) == NUM_LINES'(1)));

  // R8
  same_edge_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    $stable(pend_view) |-> $stable(cpu_vector));

endmodule

// File: tb/tb_irq_level_encoder.sv
module tb_irq_level_encoder;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 20000;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] irq_req = '0;
  logic [2:0] cpu_level;
  logic [7:0] cpu_vector;
  logic [7:0] pend_view;

  irq_level_encoder dut (
    .clk        (clk),
    .rst_n      (rst_n),
    .irq_req    (irq_req),
    .cpu_level  (cpu_level),
    .cpu_vector (cpu_vector),
    .pend_view  (pend_view)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int compared   = 0;
  int mismatched = 0;
  int cycles     = 0;

  // Reference model, behavioural.
  int edges_since_rel = 0;
  int exp_pend = 0, prev_pend = 0;
  int exp_lvl = 0, exp_vec = 0;
  bit in_reset = 1'b1;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      edges_since_rel = 0;
      prev_pend = exp_pend;
      exp_pend = 0; exp_lvl = 0; exp_vec = 0;
      in_reset = 1'b1;
    end else begin
      edges_since_rel++;
      prev_pend = exp_pend;
      if (edges_since_rel >= 3) begin
        int hi;
        in_reset = 1'b0;
        exp_pend = int'(irq_req);
        hi = -1;
        for (int i = 0; i < 8; i++) if (exp_pend[i]) hi = i;
        if (hi < 0) begin exp_lvl = 0; exp_vec = 0; end
        else begin
          exp_lvl = (hi + 1 > 7) ? 7 : hi + 1;
          exp_vec = hi + 25;
        end
      end
    end
  end

  task automatic cmp(input string tag, input string what, input int act, input int exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", tag, what, act, exp, $time);
    end
  endtask

  // Compare on every falling edge, away from the active edge.
  always @(negedge clk) begin
    string ptag, otag;
    ptag = ((prev_pend & ~exp_pend) != 0) ? "R2" : "R1";
    if (in_reset)                          otag = "R6";
    else if (exp_pend == 0)                otag = "R5";
    else if (exp_pend[7])                  otag = "R7";
    else if ($countones(exp_pend[7:0]) > 1) otag = "R3";
    else if (exp_pend != prev_pend)        otag = "R8";
    else                                   otag = "R4";
    if (in_reset) ptag = "R6";
    cmp(ptag, "pend_view", int'(pend_view), exp_pend);
    cmp(otag, "cpu_level", int'(cpu_level), exp_lvl);
    cmp(otag, "cpu_vector", int'(cpu_vector), exp_vec);
  end

  task automatic drive(input logic [7:0] v, input int hold);
    for (int k = 0; k < hold; k++) begin
      @(negedge clk);
      #1 irq_req = v;
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > WATCHDOG) begin
      mismatched++;
      $display("FAIL watchdog expired actual=%0d expected<=%0d", cycles, WATCHDOG);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    // R6: requests held high during reset must not be sampled.
    irq_req = 8'hFF;
    repeat (3) @(negedge clk);
    #1 rst_n = 1'b1;
    repeat (2) @(negedge clk);
    drive(8'h00, 2);
    // R4 R7: each line alone, R8 timing on every change.
    for (int i = 0; i < 8; i++) drive(8'(1 << i), 2);
    // R3: lower lines ignored under a higher one.
    drive(8'b0000_0111, 2);
    drive(8'b0101_0000, 2);
    drive(8'b1111_1111, 2);
    drive(8'b0011_1110, 1);
    // R2: drop the winner, the next one takes over, then all drop.
    drive(8'b0010_0110, 2);
    drive(8'b0000_0110, 2);
    drive(8'b0000_0000, 3);
    // Walking descending pairs and single-cycle pulses.
    for (int i = 7; i > 0; i--) drive(8'((1 << i) | (1 << (i-1))), 1);
    drive(8'h80, 1);
    drive(8'h00, 1);
    drive(8'h01, 1);
    drive(8'h00, 2);
    // R6: reset in the middle of activity.
    drive(8'hC3, 2);
    @(negedge clk); #1 rst_n = 1'b0;
    drive(8'hC3, 3);
    @(negedge clk); #1 rst_n = 1'b1;
    drive(8'h18, 5);
    drive(8'h00, 3);
    @(negedge clk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule